// File: doc/BRIEF.md
# Block-Lock Write Protection Unit

This block sits beside the command decoder of a serial nonvolatile memory. It keeps the status register of the part and decides, cycle by cycle, whether a requested array write or status write is allowed to go ahead. The decoder reports what it has received: enable and disable pulses for the write latch, a status data byte, chip-select activity, and the target address of each array write. The write engine reports the end of each internal write cycle. The unit answers with the status byte for read-back and with two combinational permit signals. The controller checks a permit before it starts an internal cycle.

Two zone bits choose how much of the array is locked, counting down from the top address: a quarter, a half, or all of it. A lock-enable bit lets the active-low protect pin also freeze the status register, including the lock-enable bit itself. A status write is held as pending while the part stays selected. It starts its internal cycle only when select is released, and a protect-pin drop during that window cancels it. The nonvolatile bits change only when a status cycle completes.

Top module: `wprot_unit`

## Requirements
- R1: After reset the status byte reads 0x00. Bit 7 is the lock-enable bit, bits 3:2 are the zone field, bit 1 is the write latch, bit 0 is busy, and bits 6:4 read 0 when idle.
- R2: Zone field 00 locks no address. 01 locks 0x1800-0x1FFF. 10 locks 0x1000-0x1FFF. 11 locks 0x0000-0x1FFF. `arr_permit_o` is low for a locked address.
- R3: When the lock-enable bit is 1 and `wp_n_i` is low, `sr_permit_o` is low and no status write starts, so the lock-enable bit cannot be cleared.
- R4: Both permits need the write latch set. A locked address is refused whatever the state of the pin and the lock-enable bit.
- R5: An enable pulse sets the write latch and a disable pulse clears it; the disable wins when both arrive together. The latch clears when any write cycle completes.
- R6: While a write cycle is in progress the status byte reads 0xFF.
- R7: A pending status write is cancelled if hardware lock becomes active while select is still asserted. A status cycle that has already started completes unaffected.
- R8: A status write takes only data bits 7, 3 and 2. The other bits have no effect.
- R9: The nonvolatile bits change only when a started status cycle completes. A status cycle starts only when select is released after a permitted data byte. `cycle_done_i` while idle has no effect.
- R10: During a write cycle, enable and disable pulses and new start requests are ignored, and both permits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| sel_i | input | 1 | Device selected (chip select active) |
| wp_n_i | input | 1 | Hardware protect pin, active low |
| wren_i | input | 1 | Decoded write-enable command pulse |
| wrdi_i | input | 1 | Decoded write-disable command pulse |
| srw_load_i | input | 1 | Status data byte fully received |
| srw_data_i | input | 8 | Status data byte |
| arr_start_i | input | 1 | Request to start an array write cycle |
| arr_addr_i | input | ADDR_W | Target address of the array write |
| cycle_done_i | input | 1 | Internal write cycle complete pulse |
| status_o | output | 8 | Status byte for read-back |
| arr_permit_o | output | 1 | Array write at `arr_addr_i` is allowed |
| sr_permit_o | output | 1 | Status write is allowed |

## Verification
The bench probes each zone at the addresses just below and at its lower edge (0x17FF/0x1800, 0x0FFF/0x1000). A design with a mis-decoded zone would then grant a write one address too far or refuse a legal one. It tries to clear the lock-enable bit with the pin low, which a design with a wrong lock condition would allow. It drops the pin while a status write is pending and again after the cycle has started, so a design that mixes up the two cases either commits the cancelled write or aborts the started one. It also sends latch commands and a stray done pulse while busy or idle, which would corrupt the write latch or the nonvolatile bits in a design that does not gate them.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int ADDR_W_DEF = 13;

    typedef enum logic [1:0] {
        ZONE_NONE = 2'b00,
        ZONE_QTR  = 2'b01,
        ZONE_HALF = 2'b10,
        ZONE_ALL  = 2'b11
    } zone_e;

    typedef struct packed {
        logic  lock_en;
        zone_e zone;
    } nv_t;

    typedef enum logic {
        CYC_ARRAY  = 1'b0,
        CYC_STATUS = 1'b1
    } cyc_e;

    localparam nv_t NV_RESET = '{lock_en: 1'b0, zone: ZONE_NONE};

    function automatic logic [7:0] pack_status(nv_t nv, logic wel, logic busy);
        if (busy) return 8'hFF;
        return {nv.lock_en, 3'b000, nv.zone, wel, 1'b0};
    endfunction

    function automatic nv_t take_nv(logic [7:0] d);
        nv_t r;
        r.lock_en = d[7];
        r.zone    = zone_e'(d[3:2]);
        return r;
    endfunction

endpackage

// File: rtl/wprot_zone_map.sv
module wprot_zone_map
    import wprot_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  zone_e             zone,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    logic in_top_half;
    logic in_top_qtr;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign in_top_half = addr[ADDR_W-1];
            assign in_top_qtr  = &addr[ADDR_W-1 -: 2];
        end else begin : g_narrow
            assign in_top_half = addr[0];
            assign in_top_qtr  = addr[0];
        end
    endgenerate

    always_comb begin
        unique case (zone)
            ZONE_NONE: locked = 1'b0;
            ZONE_QTR:  locked = in_top_qtr;
            ZONE_HALF: locked = in_top_half;
            default:   locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/wprot_srw_seq.sv
module wprot_srw_seq
    import wprot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       hw_lock,
    input  logic       load,
    input  logic [7:0] data,
    input  logic       sr_ok,
    input  logic       wel,
    input  logic       busy,
    output logic       commit,
    output nv_t        staged
);
    logic       pend;
    logic       sel_q;
    logic [7:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            sel_q  <= 1'b0;
            byte_q <= 8'h00;
        end else begin
            sel_q <= sel;
            if (!sel || hw_lock) begin
                pend <= 1'b0;
            end else if (load && sr_ok) begin
                pend   <= 1'b1;
                byte_q <= data;
            end
        end
    end

    assign commit = pend && sel_q && !sel && !hw_lock && wel && !busy;
    assign staged = take_nv(byte_q);

    // R7: hardware lock while a write is pending kills it
    p_cancel_on_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && hw_lock) |=> !pend);

    // R9: start only on release of select
    p_commit_on_release_r9: assert property (@(posedge clk) disable iff (rst)
        commit |-> (!sel && $past(sel)));
endmodule

// File: rtl/wprot_state.sv
module wprot_state
    import wprot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wren,
    input  logic wrdi,
    input  logic arr_go,
    input  logic sr_go,
    input  nv_t  sr_nv,
    input  logic cycle_done,
    output nv_t  nv,
    output logic wel,
    output logic busy
);
    cyc_e kind;
    nv_t  nv_stage;
    logic finish;

    assign finish = cycle_done && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            nv       <= NV_RESET;
            nv_stage <= NV_RESET;
            wel      <= 1'b0;
            busy     <= 1'b0;
            kind     <= CYC_ARRAY;
        end else if (finish) begin
            busy <= 1'b0;
            wel  <= 1'b0;
            if (kind == CYC_STATUS) nv <= nv_stage;
        end else if (!busy) begin
            if (arr_go) begin
                busy <= 1'b1;
                kind <= CYC_ARRAY;
            end else if (sr_go) begin
                busy     <= 1'b1;
                kind     <= CYC_STATUS;
                nv_stage <= sr_nv;
            end else if (wrdi) begin
                wel <= 1'b0;
            end else if (wren) begin
                wel <= 1'b1;
            end
        end
    end

    // R5: completion always drops the write latch
    p_wel_drop_r5: assert property (@(posedge clk) disable iff (rst)
        finish |=> !wel);

    // R9: nonvolatile bits hold unless a status cycle finishes
    p_nv_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(finish && kind == CYC_STATUS) |=> $stable(nv));

    // R10: a start is only taken when idle with the latch set
    p_go_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (arr_go || sr_go) |-> (!busy && wel));
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
    import wprot_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              wp_n_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              srw_load_i,
    input  logic [7:0]        srw_data_i,
    input  logic              arr_start_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              cycle_done_i,
    output logic [7:0]        status_o,
    output logic              arr_permit_o,
    output logic              sr_permit_o
);
    nv_t  nv;
    nv_t  staged;
    logic wel;
    logic busy;
    logic hw_lock;
    logic locked;
    logic commit;
    logic arr_go;
    logic sr_go;

    assign hw_lock      = nv.lock_en && !wp_n_i;
    assign arr_permit_o = wel && !busy && !locked;
    assign sr_permit_o  = wel && !busy && !hw_lock;
    assign arr_go       = arr_start_i && arr_permit_o;
    assign sr_go        = commit && !arr_go;
    assign status_o     = pack_status(nv, wel, busy);

    wprot_zone_map #(.ADDR_W(ADDR_W)) u_zone (
        .zone   (nv.zone),
        .addr   (arr_addr_i),
        .locked (locked)
    );

    wprot_srw_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel_i),
        .hw_lock (hw_lock),
        .load    (srw_load_i),
        .data    (srw_data_i),
        .sr_ok   (sr_permit_o),
        .wel     (wel),
        .busy    (busy),
        .commit  (commit),
        .staged  (staged)
    );

    wprot_state u_state (
        .clk        (clk),
        .rst        (rst),
        .wren       (wren_i),
        .wrdi       (wrdi_i),
        .arr_go     (arr_go),
        .sr_go      (sr_go),
        .sr_nv      (staged),
        .cycle_done (cycle_done_i),
        .nv         (nv),
        .wel        (wel),
        .busy       (busy)
    );

    // R6: a started cycle shows all ones next cycle
    p_ff_when_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (arr_go || sr_go) |=> (status_o == 8'hFF));

    // R2: whole-array zone refuses every address
    p_zone_all_r2: assert property (@(posedge clk) disable iff (rst)
        (status_o[3:2] == 2'b11 && !status_o[0]) |-> !arr_permit_o);

    // R3: hardware lock refuses status writes
    p_hw_lock_r3: assert property (@(posedge clk) disable iff (rst)
        (status_o[7] && !status_o[0] && !wp_n_i) |-> !sr_permit_o);

    // R4: no latch, no permit
    p_need_wel_r4: assert property (@(posedge clk) disable iff (rst)
        (!status_o[1]) |-> (!arr_permit_o && !sr_permit_o));
endmodule

// File: tb/wprot_unit_tb.sv
module wprot_unit_tb;
    localparam int CLK_NS = 10;
    localparam int AW     = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0, wp_n = 1'b1, wren = 1'b0, wrdi = 1'b0;
    logic          load = 1'b0, astart = 1'b0, done = 1'b0;
    logic [7:0]    sdata = 8'h00;
    logic [AW-1:0] addr = '0;
    logic [7:0]    status;
    logic          aperm, sperm;

    int n_chk  = 0;
    int n_fail = 0;

    wprot_unit #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .sel_i(sel), .wp_n_i(wp_n),
        .wren_i(wren), .wrdi_i(wrdi), .srw_load_i(load), .srw_data_i(sdata),
        .arr_start_i(astart), .arr_addr_i(addr), .cycle_done_i(done),
        .status_o(status), .arr_permit_o(aperm), .sr_permit_o(sperm)
    );

    always #(CLK_NS/2) clk = ~clk;

    // behavioural reference
    bit       m_lock, m_wel, m_busy, m_ksr, m_pend, m_selq;
    bit [1:0] m_zone;
    bit [7:0] m_pdata, m_stage;

    function automatic bit m_locked(bit [1:0] z, int a);
        case (z)
            2'b00:   return 0;
            2'b01:   return a >= 'h1800;
            2'b10:   return a >= 'h1000;
            default: return 1;
        endcase
    endfunction

    function automatic bit [7:0] m_status();
        if (m_busy) return 8'hFF;
        return {m_lock, 3'b000, m_zone, m_wel, 1'b0};
    endfunction

    function automatic bit m_arr();
        return m_wel && !m_busy && !m_locked(m_zone, int'(addr));
    endfunction

    function automatic bit m_sr();
        return m_wel && !m_busy && !(m_lock && !wp_n);
    endfunction

    always @(posedge clk) begin
        bit hw, ea, es, rel;
        if (rst) begin
            m_lock = 0; m_zone = 0; m_wel = 0; m_busy = 0; m_ksr = 0;
            m_pend = 0; m_selq = 0; m_pdata = 0; m_stage = 0;
        end else begin
            hw  = m_lock && !wp_n;
            ea  = m_arr();
            es  = m_sr();
            rel = m_selq && !sel;
            if (m_busy && done) begin
                m_busy = 0; m_wel = 0;
                if (m_ksr) begin
                    m_lock = m_stage[7];
                    m_zone = m_stage[3:2];
                end
            end else if (!m_busy) begin
                if (astart && ea) begin
                    m_busy = 1; m_ksr = 0;
                end else if (rel && m_pend && !hw && m_wel) begin
                    m_busy = 1; m_ksr = 1; m_stage = m_pdata;
                end else if (wrdi) m_wel = 0;
                else if (wren) m_wel = 1;
            end
            if (!sel || hw) m_pend = 0;
            else if (load && es) begin
                m_pend = 1; m_pdata = sdata;
            end
            m_selq = sel;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // compare on every clock, before new inputs are applied
    always @(negedge clk) begin
        if (!rst) begin
            chk("R1/R6 status", status, m_status());
            chk("R2/R4 array permit", {7'd0, aperm}, {7'd0, m_arr()});
            chk("R3/R4 status permit", {7'd0, sperm}, {7'd0, m_sr()});
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_wren();
        wren = 1; cyc(); wren = 0;
    endtask

    task automatic finish_cycle();
        done = 1; cyc(); done = 0;
    endtask

    task automatic status_write(logic [7:0] d);
        pulse_wren();
        sel = 1; cyc();
        sdata = d; load = 1; cyc(); load = 0;
        sel = 0; cyc();
    endtask

    task automatic probe(string req, int a, logic exp);
        addr = a[AW-1:0];
        #1;
        chk(req, {7'd0, aperm}, {7'd0, exp});
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 0;
        cyc();
        chk("R1 reset status", status, 8'h00);
        chk("R4 no latch array", {7'd0, aperm}, 8'h00);

        // R5 latch set, clear, both together
        pulse_wren();
        chk("R5 set latch", status, 8'h02);
        wren = 1; wrdi = 1; cyc(); wren = 0; wrdi = 0;
        chk("R5 disable wins", status, 8'h00);

        // array write, busy view, ignored commands
        pulse_wren();
        addr = 'h1FFF;
        astart = 1; cyc(); astart = 0;
        chk("R6 busy reads FF", status, 8'hFF);
        chk("R10 permit low busy", {7'd0, aperm}, 8'h00);
        wrdi = 1; cyc(); wrdi = 0;
        finish_cycle();
        chk("R5 latch cleared by completion", status, 8'h00);
        finish_cycle();
        chk("R9 stray done ignored", status, 8'h00);

        // R8 only bits 7,3,2 kept
        status_write(8'hFF);
        chk("R6 status cycle busy", status, 8'hFF);
        finish_cycle();
        chk("R8 masked status", status, 8'h8C);

        // R3 hardware lock prevents clearing lock-enable
        wp_n = 0;
        pulse_wren();
        chk("R3 permit refused", {7'd0, sperm}, 8'h00);
        sel = 1; cyc(); sdata = 8'h00; load = 1; cyc(); load = 0; sel = 0; cyc(2);
        chk("R3 lock bit kept", status, 8'h8E);
        probe("R4 whole array locked", 0, 0);
        wp_n = 1; cyc();
        probe("R4 locked with pin high", 'h0100, 0);

        // R2 zone edges
        status_write(8'h04); finish_cycle();
        chk("R2 zone quarter", status, 8'h04);
        pulse_wren();
        probe("R2 qtr below edge", 'h17FF, 1);
        probe("R2 qtr at edge", 'h1800, 0);
        status_write(8'h08); finish_cycle();
        pulse_wren();
        probe("R2 half below edge", 'h0FFF, 1);
        probe("R2 half at edge", 'h1000, 0);
        status_write(8'h00); finish_cycle();
        pulse_wren();
        probe("R2 none top", 'h1FFF, 1);
        wrdi = 1; cyc(); wrdi = 0;

        // R7 cancel while pending
        status_write(8'h80); finish_cycle();
        pulse_wren();
        sel = 1; cyc(); sdata = 8'h08; load = 1; cyc(); load = 0;
        wp_n = 0; cyc(); wp_n = 1; cyc();
        sel = 0; cyc(2);
        chk("R7 pending cancelled", status, 8'h82);

        // R7 started cycle unaffected
        sel = 1; cyc(); sdata = 8'h00; load = 1; cyc(); load = 0;
        sel = 0; cyc();
        chk("R7 cycle started", status, 8'hFF);
        wp_n = 0; cyc(2);
        finish_cycle();
        wp_n = 1;
        chk("R7 started write completed", status, 8'h00);

        // R9 no release, no commit
        pulse_wren();
        sel = 1; cyc(); sdata = 8'h0C; load = 1; cyc(); load = 0; cyc(3);
        chk("R9 held select no commit", status, 8'h02);
        sel = 0; cyc(); finish_cycle();
        chk("R9 commit after release", status, 8'h0C);

        cyc(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule